// File: doc/BRIEF.md
# USB Endpoint Handshake Control

This block holds the control and configuration state of one endpoint in a USB device controller. It decides how the endpoint answers each token. Software reaches it through a two-register write/read port. Through that port it can turn the endpoint on or off, set the endpoint type and direction, raise a STALL request, cancel that request, and force the data toggle back to DATA0. The STALL request and the toggle reset can only be set by software; hardware clears them.

The packet engine tells the block about three things: a token arriving (with a flag for SETUP and a buffer-ready flag), a SETUP packet that has been received, and a transaction that completed with ACK. For each token the block returns a registered handshake code one cycle later, together with the data PID parity to expect or to send. Bus signalling, CRC, FIFO storage and descriptor handling sit outside the block.

Top module: `ep_hshk_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, the endpoint is enabled only when parameter `EP_INDEX` is 0. The STALL request, the toggle and the configuration register are 0, and `hs_o` is NONE.
- R2: The configuration register (`reg_addr_i`=1) stores the endpoint type in bits 7:6 and the direction in bit 0. Its bits 5:1 always read 0.
- R3: The control register (`reg_addr_i`=0) reads enable in bit 0 and the STALL request in bit 1. The cancel bit (bit 2), the toggle-reset bit (bit 3) and bits 7:4 always read 0.
- R4: A token with `tok_setup_i`=0 on an enabled endpoint gives a code on `hs_o` in the cycle after the token. The code is STALL (2'b11) if a STALL request is pending, otherwise ACK (2'b01) if `buf_rdy_i` is 1, otherwise NAK (2'b10). NONE is 2'b00. `data_par_o` shows the current toggle.
- R5: Writing 1 to control bit 1 raises the STALL request. Writing 0 to that bit leaves the request unchanged.
- R6: A `setup_rx_i` pulse clears the STALL request.
- R7: Writing 1 to control bit 2 clears the STALL request. This also holds when bit 1 is written as 1 in the same write.
- R8: The toggle inverts after each `xfer_ack_i` pulse on an enabled endpoint. NAK or STALL answers without that pulse leave it unchanged.
- R9: A SETUP token on an enabled endpoint is answered with ACK and parity 0, even while a STALL request is pending. A `setup_rx_i` pulse sets the toggle to 1, so the first data-stage packet is DATA1.
- R10: Writing 1 to control bit 3 sets the toggle to 0 in the next cycle. Writing 0 there has no effect on the toggle.
- R11: While disabled (control bit 0 = 0), tokens give NONE with parity 0. `xfer_ack_i` and `setup_rx_i` then leave the toggle unchanged.
- R12: A `bus_rst_i` pulse returns enable, STALL request, toggle and configuration to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_i | input | 1 | USB bus reset seen on the line |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = configuration |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data of the addressed register |
| tok_vld_i | input | 1 | Token seen for this endpoint |
| tok_setup_i | input | 1 | The token is SETUP |
| buf_rdy_i | input | 1 | Endpoint buffer can take or supply a packet |
| setup_rx_i | input | 1 | SETUP packet received |
| xfer_ack_i | input | 1 | Transaction completed with ACK |
| hs_o | output | 2 | Handshake code: 00 NONE, 01 ACK, 10 NAK, 11 STALL |
| data_par_o | output | 1 | Data PID parity for the answered token |

## Verification
Tokens are sent with the buffer ready and not ready, with and without a pending STALL, and as SETUP versus plain tokens. These patterns separate the ACK, NAK and STALL paths and show that SETUP overrides STALL. Each toggle change is observed on the parity of a later token: after an ACK pulse, after a NAK, after a toggle-reset write and its 0 write, and after SETUP reception. Together these tell flipping, holding and forced values apart. Disabled-endpoint tokens, request-with-cancel writes and a bus reset applied over non-default state cover the override cases.

// File: rtl/ep_hs_pkg.sv
// Package: shared encodings and register bit positions for the endpoint
// handshake controller. Assumes 8-bit or wider registers.
package ep_hs_pkg;
    localparam int unsigned CTL_EN_BIT     = 0;
    localparam int unsigned CTL_STALL_BIT  = 1;
    localparam int unsigned CTL_CANCEL_BIT = 2;
    localparam int unsigned CTL_TOGRST_BIT = 3;
    localparam int unsigned CFG_DIR_BIT    = 0;
    localparam int unsigned CFG_TYPE_LSB   = 6;
    localparam int unsigned TYPE_W         = 2;
    localparam logic        ADDR_CTL       = 1'b0;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;
endpackage

// File: rtl/ep_cfg_regs.sv
// Register file: enable, STALL request and configuration fields. It also
// decodes the self-clearing strobes (cancel, toggle reset). Assumes
// REG_W >= CFG_TYPE_LSB + TYPE_W. Strobe bits are never stored.
module ep_cfg_regs
    import ep_hs_pkg::*;
#(
    parameter int unsigned EP_INDEX = 0,
    parameter int unsigned REG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    input  logic             setup_rx_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             en_o,
    output logic             stall_o,
    output logic             tog_rst_o
);
    localparam logic EN_RST = (EP_INDEX == 0);

    logic              ctl_wr, cfg_wr;
    logic              req_set, req_clr;
    logic              en_q, stall_q, dir_q;
    logic [TYPE_W-1:0] type_q;
    logic              unused_wbits;

    assign ctl_wr       = reg_wr_i && (reg_addr_i == ADDR_CTL);
    assign cfg_wr       = reg_wr_i && (reg_addr_i != ADDR_CTL);
    assign req_set      = ctl_wr && reg_wdata_i[CTL_STALL_BIT];
    assign req_clr      = (ctl_wr && reg_wdata_i[CTL_CANCEL_BIT]) || setup_rx_i;
    assign tog_rst_o    = ctl_wr && reg_wdata_i[CTL_TOGRST_BIT];
    assign unused_wbits = ^reg_wdata_i;

    // Enable bit: reset value depends on endpoint number.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst_i) en_q <= EN_RST;
        else if (ctl_wr)         en_q <= reg_wdata_i[CTL_EN_BIT];
    end

    // STALL request: set only by software, cleared by cancel or SETUP.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst_i) stall_q <= 1'b0;
        else if (req_clr)        stall_q <= 1'b0;
        else if (req_set)        stall_q <= 1'b1;
    end

    // Configuration fields: type and direction.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst_i) begin
            type_q <= '0;
            dir_q  <= 1'b0;
        end else if (cfg_wr) begin
            type_q <= reg_wdata_i[CFG_TYPE_LSB +: TYPE_W];
            dir_q  <= reg_wdata_i[CFG_DIR_BIT];
        end
    end

    // Read mux: reserved and strobe positions stay 0.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_CTL) begin
            reg_rdata_o[CTL_EN_BIT]    = en_q;
            reg_rdata_o[CTL_STALL_BIT] = stall_q;
        end else begin
            reg_rdata_o[CFG_DIR_BIT]                 = dir_q;
            reg_rdata_o[CFG_TYPE_LSB +: TYPE_W]      = type_q;
        end
    end

    assign en_o    = en_q;
    assign stall_o = stall_q;
endmodule

// File: rtl/ep_toggle.sv
// Data toggle state. Priority: SETUP reception (to 1), then the software
// reset (to 0), then the ACK flip. Events are ignored while disabled; the
// software reset works in any state.
module ep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_i,
    input  logic en_i,
    input  logic setup_rx_i,
    input  logic tog_rst_i,
    input  logic xfer_ack_i,
    output logic tog_o
);
    logic tog_q;

    // Toggle update from events and software strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst_i)      tog_q <= 1'b0;
        else if (en_i && setup_rx_i)  tog_q <= 1'b1;
        else if (tog_rst_i)           tog_q <= 1'b0;
        else if (en_i && xfer_ack_i)  tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/ep_resp.sv
// Handshake decision. Registers the answer to a token so that it appears
// one cycle after the token. Assumes at most one token per cycle.
module ep_resp
    import ep_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst_i,
    input  logic       en_i,
    input  logic       stall_i,
    input  logic       tog_i,
    input  logic       tok_vld_i,
    input  logic       tok_setup_i,
    input  logic       buf_rdy_i,
    output logic [1:0] hs_o,
    output logic       par_o
);
    hs_e  hs_d, hs_q;
    logic par_d, par_q;

    // Choose the handshake and parity for the current token.
    always_comb begin
        hs_d  = HS_NONE;
        par_d = 1'b0;
        if (tok_vld_i && en_i) begin
            if (tok_setup_i) begin
                hs_d  = HS_ACK;
                par_d = 1'b0;
            end else begin
                par_d = tog_i;
                if (stall_i)        hs_d = HS_STALL;
                else if (buf_rdy_i) hs_d = HS_ACK;
                else                hs_d = HS_NAK;
            end
        end
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst_i) begin
            hs_q  <= HS_NONE;
            par_q <= 1'b0;
        end else begin
            hs_q  <= hs_d;
            par_q <= par_d;
        end
    end

    assign hs_o  = hs_q;
    assign par_o = par_q;
endmodule

// File: rtl/ep_hshk_ctrl.sv
// Top: per-endpoint handshake control. It joins the register file, the
// toggle state and the response logic. The packet engine pulses each event
// for one cycle.
module ep_hshk_ctrl #(
    parameter int unsigned EP_INDEX = 0,
    parameter int unsigned REG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             tok_vld_i,
    input  logic             tok_setup_i,
    input  logic             buf_rdy_i,
    input  logic             setup_rx_i,
    input  logic             xfer_ack_i,
    output logic [1:0]       hs_o,
    output logic             data_par_o
);
    logic en_w, stall_w, tog_rst_w, tog_w;

    ep_cfg_regs #(.EP_INDEX(EP_INDEX), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .setup_rx_i(setup_rx_i), .reg_rdata_o(reg_rdata_o),
        .en_o(en_w), .stall_o(stall_w), .tog_rst_o(tog_rst_w)
    );

    ep_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .en_i(en_w),
        .setup_rx_i(setup_rx_i), .tog_rst_i(tog_rst_w),
        .xfer_ack_i(xfer_ack_i), .tog_o(tog_w)
    );

    ep_resp u_resp (
        .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .en_i(en_w),
        .stall_i(stall_w), .tog_i(tog_w), .tok_vld_i(tok_vld_i),
        .tok_setup_i(tok_setup_i), .buf_rdy_i(buf_rdy_i),
        .hs_o(hs_o), .par_o(data_par_o)
    );
endmodule

// File: rtl/ep_hshk_chk.sv
// Checker: temporal properties of the endpoint handshake controller,
// attached to every instance of the top by the bind below.
module ep_hshk_chk
    import ep_hs_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rst_i,
    input logic             reg_wr_i,
    input logic             reg_addr_i,
    input logic [REG_W-1:0] reg_wdata_i,
    input logic [REG_W-1:0] reg_rdata_o,
    input logic             tok_vld_i,
    input logic             tok_setup_i,
    input logic             setup_rx_i,
    input logic             xfer_ack_i,
    input logic [1:0]       hs_o,
    input logic             data_par_o,
    input logic             en_w,
    input logic             stall_w,
    input logic             tog_w
);
    localparam logic [REG_W-1:0] CFG_KEEP =
        ({{(REG_W-TYPE_W){1'b0}}, {TYPE_W{1'b1}}} << CFG_TYPE_LSB) | REG_W'(1);
    localparam logic [REG_W-1:0] CTL_KEEP = REG_W'(3);

    logic ctl_wr, tog_rst_wr;
    assign ctl_wr     = reg_wr_i && (reg_addr_i == ADDR_CTL);
    assign tog_rst_wr = ctl_wr && reg_wdata_i[CTL_TOGRST_BIT];

    AST_RESV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & ~((reg_addr_i == ADDR_CTL) ? CTL_KEEP : CFG_KEEP)) == '0); // R3
    AST_REQ_SETS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata_i[CTL_STALL_BIT] && !reg_wdata_i[CTL_CANCEL_BIT]
         && !setup_rx_i && !bus_rst_i) |=> stall_w); // R5
    AST_SETUP_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rx_i |=> !stall_w); // R6
    AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && reg_wdata_i[CTL_CANCEL_BIT]) |=> !stall_w); // R7
    AST_ACK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && xfer_ack_i && !setup_rx_i && !tog_rst_wr && !bus_rst_i)
        |=> (tog_w != $past(tog_w))); // R8
    AST_SETUP_TOKEN_DATA0: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld_i && tok_setup_i && en_w && !bus_rst_i)
        |=> (hs_o == HS_ACK && !data_par_o)); // R9
    AST_OFF_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld_i && !en_w) |=> (hs_o == HS_NONE)); // R11
    AST_OFF_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && !bus_rst_i && !tog_rst_wr) |=> $stable(tog_w)); // R11
endmodule

bind ep_hshk_ctrl ep_hshk_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .tok_vld_i(tok_vld_i), .tok_setup_i(tok_setup_i), .setup_rx_i(setup_rx_i),
    .xfer_ack_i(xfer_ack_i), .hs_o(hs_o), .data_par_o(data_par_o),
    .en_w(en_w), .stall_w(stall_w), .tog_w(tog_w)
);

// File: tb/ep_hshk_ctrl_tb.sv
// Scoreboard bench: token tasks queue expected answers, a monitor compares.
module ep_hshk_ctrl_tb;
    localparam int REG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_rst_i = 1'b0;
    logic             reg_wr_i = 1'b0;
    logic             reg_addr_i = 1'b0;
    logic [REG_W-1:0] reg_wdata_i = '0;
    logic [REG_W-1:0] reg_rdata_o;
    logic             tok_vld_i = 1'b0, tok_setup_i = 1'b0, buf_rdy_i = 1'b0;
    logic             setup_rx_i = 1'b0, xfer_ack_i = 1'b0;
    logic [1:0]       hs_o;
    logic             data_par_o;

    typedef struct {
        int         due;
        logic [1:0] hs;
        logic       par;
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_vec = 0, n_err = 0, cyc = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ep_hshk_ctrl #(.EP_INDEX(0), .REG_W(REG_W)) u_dut (.*);

    // Monitor: compares queued answers in the cycle they are due.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (hs_o !== e.hs || data_par_o !== e.par) begin
                n_err++;
                $display("FAIL %s: hs/par actual %b/%b expected %b/%b",
                         e.tag, hs_o, data_par_o, e.hs, e.par);
            end
        end
    end

    task automatic wr(input logic a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic a, input logic [REG_W-1:0] exp, input string tag);
        @(negedge clk);
        reg_addr_i = a;
        #1;
        n_vec++;
        if (reg_rdata_o !== exp) begin
            n_err++;
            $display("FAIL %s: rdata actual %h expected %h", tag, reg_rdata_o, exp);
        end
    endtask

    task automatic tok(input logic setup, input logic rdy, input logic [1:0] ehs,
                       input logic epar, input string tag);
        exp_t e;
        @(negedge clk);
        tok_vld_i = 1'b1; tok_setup_i = setup; buf_rdy_i = rdy;
        e.due = cyc + 1; e.hs = ehs; e.par = epar; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        tok_vld_i = 1'b0; tok_setup_i = 1'b0;
    endtask

    task automatic evt(input logic srx, input logic ack);
        @(negedge clk);
        setup_rx_i = srx; xfer_ack_i = ack;
        @(negedge clk);
        setup_rx_i = 1'b0; xfer_ack_i = 1'b0;
    endtask

    localparam logic [1:0] NONE = 2'b00, ACK = 2'b01, NAK = 2'b10, STL = 2'b11;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_vec++;
        if (hs_o !== NONE) begin
            n_err++;
            $display("FAIL R1: hs after reset actual %b expected %b", hs_o, NONE);
        end
        rd(1'b0, 8'h01, "R1 ctl reset");
        rd(1'b1, 8'h00, "R1 cfg reset");
        tok(0, 1, ACK, 0, "R1 toggle starts 0");
        wr(1'b1, 8'hFF); rd(1'b1, 8'hC1, "R2 cfg reserved zero");
        wr(1'b1, 8'h40); rd(1'b1, 8'h40, "R2 cfg type field");
        wr(1'b0, 8'hF1); rd(1'b0, 8'h01, "R3 ctl reserved zero");
        tok(0, 1, ACK, 0, "R4 ready gives ACK");
        evt(0, 1);
        tok(0, 1, ACK, 1, "R8 flip after ACK");
        tok(0, 0, NAK, 1, "R4 not ready gives NAK");
        tok(0, 1, ACK, 1, "R8 hold after NAK");
        evt(0, 1);
        tok(0, 1, ACK, 0, "R8 second flip");
        wr(1'b0, 8'h03); rd(1'b0, 8'h03, "R5 request set");
        tok(0, 1, STL, 0, "R4 R5 STALL answer");
        wr(1'b0, 8'h01); rd(1'b0, 8'h03, "R5 write 0 ignored");
        tok(0, 1, STL, 0, "R5 still STALL");
        tok(1, 0, ACK, 0, "R9 SETUP token ACK DATA0");
        evt(1, 0);
        rd(1'b0, 8'h01, "R6 SETUP clears request");
        tok(0, 1, ACK, 1, "R9 data stage DATA1");
        wr(1'b0, 8'h09); rd(1'b0, 8'h01, "R3 R10 strobe reads 0");
        tok(0, 1, ACK, 0, "R10 toggle forced 0");
        evt(0, 1);
        wr(1'b0, 8'h01);
        tok(0, 1, ACK, 1, "R10 write 0 no effect");
        wr(1'b0, 8'h03); wr(1'b0, 8'h05); rd(1'b0, 8'h01, "R7 cancel clears");
        tok(0, 1, ACK, 1, "R7 ACK after cancel");
        wr(1'b0, 8'h07); rd(1'b0, 8'h01, "R7 cancel wins");
        tok(0, 1, ACK, 1, "R7 no STALL after tie");
        wr(1'b0, 8'h00); rd(1'b0, 8'h00, "R11 disabled");
        tok(0, 1, NONE, 0, "R11 no handshake");
        tok(1, 1, NONE, 0, "R11 no SETUP handshake");
        evt(0, 1); evt(1, 0);
        wr(1'b0, 8'h01);
        tok(0, 1, ACK, 1, "R11 toggle held");
        wr(1'b1, 8'h81); wr(1'b0, 8'h03);
        @(negedge clk); bus_rst_i = 1'b1;
        @(negedge clk); bus_rst_i = 1'b0;
        rd(1'b0, 8'h01, "R12 ctl after bus reset");
        rd(1'b1, 8'h00, "R12 cfg after bus reset");
        tok(0, 1, ACK, 0, "R12 toggle after bus reset");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule